// File: doc/BRIEF.md
# Serial NAND Write-Protect Controller

This block switches a serial NAND flash between write-enabled and write-protected by editing the flash's protection feature register. A host raises a one-cycle request strobe with the state it wants. The controller reads the register over single-line SPI and computes the new value. It raises the hardware write-protect pin and writes the value back. It then lowers the pin again and reads the register once more to confirm the write. The write-protect pin only guards the protection register, so it is left high for the register update alone.

The three block-protect bits are always set or cleared. A configuration input chooses whether bit 7, the register-write-disable bit, moves with them. Every other bit is written back as it was read. A request that matches the state already held finishes at once and generates no bus traffic. The exported write-enabled flag changes only when the readback confirms the write, so a page-operation sequencer can use it to gate programs and erases.

Top module: `wpc_wp_ctrl`

## Requirements
- R1: After reset, wp_n is 0, spi_cs_n is 1, spi_sck is 0, wr_enabled is 0 and done is 0.
- R2: When req_enable equals wr_enabled, a strobe gives done=1 with err=0 in the cycle after the strobe, and spi_cs_n stays high.
- R3: Every SPI frame uses mode 0 (clock idles low, data sampled on the rising edge, most significant bit first). It is 24 clocks long: an 8-bit command, the 8-bit register address 0xA0, then one data byte.
- R4: The protection register is read with command 0x0F. A request to enable writes clears bits 5:3 (mask 0x38), and a request to disable writes sets them.
- R5: With cfg_manage_rwd=1, bit 7 (0x80) is cleared on enable and set on disable. With cfg_manage_rwd=0, bit 7 keeps the value that was read.
- R6: Bits 6 and 2:0 of the written value equal the bits that were read.
- R7: The new value is written with command 0x1F to address 0xA0, and then read back with command 0x0F.
- R8: wp_n is 1 only around the write frame. It rises at least 2*SCK_HALF clock cycles before spi_cs_n falls for that frame, and falls at least 2*SCK_HALF cycles after spi_cs_n rises. It is 0 during both read frames and whenever done is high.
- R9: After the readback, done pulses. If the readback matches, err=0 and wr_enabled takes the requested state. If it differs, err=1 and wr_enabled is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | One-cycle request strobe, sampled while idle |
| req_enable | input | 1 | Requested state: 1 enables writes, 0 protects |
| cfg_manage_rwd | input | 1 | Also drive bit 7 of the protection register |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Readback mismatch, valid with done |
| wr_enabled | output | 1 | Current write-enabled state |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| wp_n | output | 1 | Write-protect pin, active low |

## Verification
The flash model starts from register patterns that mix ones and zeros in bit 7, bit 6 and bits 2:0. A wrong mask therefore shows up as a changed bit that should have been kept, or a kept bit that should have changed. Requests alternate between enable and disable, with the bit-7 option both on and off. This separates the two masks and shows whether bit 7 follows the option. Repeated requests for the state already held check that there is no bus traffic. A model that ignores writes forces a readback mismatch, to show that err rises and that the flag holds its old value.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam logic [7:0] CMD_GET_FEAT = 8'h0F;
  localparam logic [7:0] CMD_SET_FEAT = 8'h1F;
  localparam logic [7:0] ADDR_PROT    = 8'hA0;
  localparam logic [7:0] MASK_BP      = 8'h38;
  localparam logic [7:0] MASK_RWD     = 8'h80;

  typedef enum logic [1:0] {FR_IDLE, FR_SHIFT, FR_TAIL} frame_state_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_READ, SQ_LEAD, SQ_WRITE, SQ_TAIL, SQ_VERIFY
  } seq_state_t;

  // Bits touched by a request, depending on the bit-7 option
  function automatic logic [7:0] managed_mask(input logic manage_rwd);
    return MASK_BP | (manage_rwd ? MASK_RWD : 8'h00);
  endfunction

  // New register value: clear managed bits to allow writes, set them to protect
  function automatic logic [7:0] prot_next(input logic [7:0] cur,
                                           input logic want_writes,
                                           input logic manage_rwd);
    logic [7:0] m;
    m = managed_mask(manage_rwd);
    return want_writes ? (cur & ~m) : (cur | m);
  endfunction

  function automatic logic [23:0] frame_word(input logic [7:0] cmd,
                                             input logic [7:0] data);
    return {cmd, ADDR_PROT, data};
  endfunction
endpackage

// File: rtl/wpc_spi_frame.sv
module wpc_spi_frame
  import wpc_pkg::*;
#(
  parameter int SCK_HALF   = 2,
  parameter int FRAME_BITS = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] tx_word,
  output logic                  frame_done,
  output logic [7:0]            rx_byte,
  output logic                  sck,
  output logic                  cs_n,
  output logic                  mosi,
  input  logic                  miso
);
  localparam int HW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [HW-1:0] HALF_LAST = HW'(SCK_HALF - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME_BITS - 1);

  frame_state_t          st;
  logic [FRAME_BITS-1:0] shreg;
  logic [BW-1:0]         bitc;
  logic [HW-1:0]         hcnt;
  logic                  half_end;

  assign half_end = (hcnt == HALF_LAST);
  assign mosi     = shreg[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= FR_IDLE;
      shreg      <= '0;
      bitc       <= '0;
      hcnt       <= '0;
      sck        <= 1'b0;
      cs_n       <= 1'b1;
      rx_byte    <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      unique case (st)
        FR_IDLE: begin
          if (start) begin
            cs_n  <= 1'b0;
            shreg <= tx_word;
            bitc  <= '0;
            hcnt  <= '0;
            st    <= FR_SHIFT;
          end
        end
        FR_SHIFT: begin
          if (half_end) begin
            hcnt <= '0;
            if (!sck) begin
              sck     <= 1'b1;
              rx_byte <= {rx_byte[6:0], miso};
            end else begin
              sck   <= 1'b0;
              shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
              if (bitc == BIT_LAST) st <= FR_TAIL;
              else                  bitc <= bitc + 1'b1;
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        FR_TAIL: begin
          if (half_end) begin
            hcnt       <= '0;
            cs_n       <= 1'b1;
            frame_done <= 1'b1;
            st         <= FR_IDLE;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        default: st <= FR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wpc_wp_seq.sv
module wpc_wp_seq
  import wpc_pkg::*;
#(
  parameter int GUARD = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_enable,
  input  logic        cfg_manage_rwd,
  input  logic        frame_done,
  input  logic [7:0]  rx_byte,
  output logic        frame_start,
  output logic [23:0] frame_tx,
  output logic        wp_n,
  output logic        done,
  output logic        err,
  output logic        wr_enabled,
  output logic        idle
);
  localparam int GW = (GUARD > 1) ? $clog2(GUARD) : 1;
  localparam logic [GW-1:0] GUARD_LAST = GW'(GUARD - 1);

  seq_state_t    st;
  logic          target_q;
  logic          manage_q;
  logic [7:0]    new_val;
  logic [GW-1:0] gcnt;
  logic          guard_end;

  assign guard_end = (gcnt == GUARD_LAST);
  assign idle      = (st == SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= SQ_IDLE;
      target_q    <= 1'b0;
      manage_q    <= 1'b0;
      new_val     <= '0;
      gcnt        <= '0;
      wp_n        <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
      wr_enabled  <= 1'b0;
      frame_start <= 1'b0;
      frame_tx    <= '0;
    end else begin
      done        <= 1'b0;
      err         <= 1'b0;
      frame_start <= 1'b0;
      unique case (st)
        SQ_IDLE: begin
          if (req_valid) begin
            if (req_enable == wr_enabled) begin
              done <= 1'b1;
            end else begin
              target_q    <= req_enable;
              manage_q    <= cfg_manage_rwd;
              frame_tx    <= frame_word(CMD_GET_FEAT, 8'h00);
              frame_start <= 1'b1;
              st          <= SQ_READ;
            end
          end
        end
        SQ_READ: begin
          if (frame_done) begin
            new_val <= prot_next(rx_byte, target_q, manage_q);
            wp_n    <= 1'b1;
            gcnt    <= '0;
            st      <= SQ_LEAD;
          end
        end
        SQ_LEAD: begin
          if (guard_end) begin
            frame_tx    <= frame_word(CMD_SET_FEAT, new_val);
            frame_start <= 1'b1;
            st          <= SQ_WRITE;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        SQ_WRITE: begin
          if (frame_done) begin
            gcnt <= '0;
            st   <= SQ_TAIL;
          end
        end
        SQ_TAIL: begin
          if (guard_end) begin
            wp_n        <= 1'b0;
            frame_tx    <= frame_word(CMD_GET_FEAT, 8'h00);
            frame_start <= 1'b1;
            st          <= SQ_VERIFY;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        SQ_VERIFY: begin
          if (frame_done) begin
            done <= 1'b1;
            if (rx_byte == new_val) wr_enabled <= target_q;
            else                    err        <= 1'b1;
            st <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wpc_wp_ctrl.sv
module wpc_wp_ctrl
  import wpc_pkg::*;
#(
  parameter int SCK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_enable,
  input  logic cfg_manage_rwd,
  output logic done,
  output logic err,
  output logic wr_enabled,
  output logic spi_sck,
  output logic spi_cs_n,
  output logic spi_mosi,
  input  logic spi_miso,
  output logic wp_n
);
  localparam int GUARD = 2 * SCK_HALF;

  logic        frame_start;
  logic [23:0] frame_tx;
  logic        frame_done;
  logic [7:0]  rx_byte;
  logic        seq_idle;

  wpc_wp_seq #(.GUARD(GUARD)) i_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_enable(req_enable),
    .cfg_manage_rwd(cfg_manage_rwd),
    .frame_done(frame_done), .rx_byte(rx_byte),
    .frame_start(frame_start), .frame_tx(frame_tx),
    .wp_n(wp_n), .done(done), .err(err),
    .wr_enabled(wr_enabled), .idle(seq_idle)
  );

  wpc_spi_frame #(.SCK_HALF(SCK_HALF), .FRAME_BITS(24)) i_frame (
    .clk(clk), .rst_n(rst_n),
    .start(frame_start), .tx_word(frame_tx),
    .frame_done(frame_done), .rx_byte(rx_byte),
    .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
  );
endmodule

// File: rtl/wpc_wp_ctrl_chk.sv
module wpc_wp_ctrl_chk #(
  parameter int SCK_HALF = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_enable,
  input logic done,
  input logic err,
  input logic wr_enabled,
  input logic spi_sck,
  input logic spi_cs_n,
  input logic wp_n,
  input logic seq_idle
);
  localparam int GUARD = 2 * SCK_HALF;

  logic [15:0] wp_hi_cnt;
  logic [15:0] cs_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_hi_cnt <= '0;
      cs_hi_cnt <= '0;
    end else begin
      wp_hi_cnt <= !wp_n ? 16'd0 : ((wp_hi_cnt == 16'hFFFF) ? wp_hi_cnt : wp_hi_cnt + 16'd1);
      cs_hi_cnt <= !spi_cs_n ? 16'd0 : ((cs_hi_cnt == 16'hFFFF) ? cs_hi_cnt : cs_hi_cnt + 16'd1);
    end
  end

  AST_WP_LEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(spi_cs_n) && wp_n) |-> (wp_hi_cnt >= 16'(GUARD))); // R8
  AST_WP_TAIL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wp_n) |-> (spi_cs_n && cs_hi_cnt >= 16'(GUARD))); // R8
  AST_WP_RISE_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wp_n) |-> spi_cs_n); // R8
  AST_DONE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_cs_n && !wp_n)); // R8
  AST_MATCH_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && req_valid && (req_enable == wr_enabled)) |=> (done && !err && spi_cs_n)); // R2
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R3
  AST_FLAG_ON_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_enabled) |-> (done && !err)); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R9
endmodule

bind wpc_wp_ctrl wpc_wp_ctrl_chk #(.SCK_HALF(SCK_HALF)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_enable(req_enable),
  .done(done), .err(err), .wr_enabled(wr_enabled), .spi_sck(spi_sck),
  .spi_cs_n(spi_cs_n), .wp_n(wp_n), .seq_idle(seq_idle)
);

// File: tb/test_wpc_wp_ctrl.sv
`timescale 1ns/1ps
module test_wpc_wp_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_enable = 1'b0, cfg_manage_rwd = 1'b0;
  logic done, err, wr_enabled, spi_sck, spi_cs_n, spi_mosi, spi_miso, wp_n;

  always #2.5 clk = ~clk;

  wpc_wp_ctrl #(.SCK_HALF(2)) i_wpc_wp_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_enable(req_enable),
    .cfg_manage_rwd(cfg_manage_rwd), .done(done), .err(err),
    .wr_enabled(wr_enabled), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .wp_n(wp_n)
  );

  int n_checks = 0;
  int n_fails  = 0;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0]  flash_reg = 8'h00;
  logic        flash_lock = 1'b0;
  logic        armed = 1'b0;
  int          nbits = 0;
  logic [23:0] mosi_sh = '0;
  logic        wp_at_fall = 1'b0;
  int          n_get = 0, n_set = 0, n_bad = 0, n_wp_bad = 0;

  always @(negedge spi_cs_n) if (armed) begin
    nbits = 0;
    wp_at_fall = wp_n;
  end

  always @(posedge spi_sck) if (armed && !spi_cs_n) begin
    mosi_sh = {mosi_sh[22:0], spi_mosi};
    nbits++;
  end

  assign spi_miso = (nbits >= 16 && nbits < 24) ? flash_reg[23 - nbits] : 1'b0;

  always @(posedge spi_cs_n) if (armed) begin
    if (nbits != 24) n_bad++;
    else if (mosi_sh[23:8] == 16'h0FA0) begin
      n_get++;
      if (wp_at_fall || wp_n) n_wp_bad++;
    end else if (mosi_sh[23:8] == 16'h1FA0) begin
      n_set++;
      if (!wp_at_fall || !wp_n) n_wp_bad++;
      if (!flash_lock) flash_reg = mosi_sh[7:0];
    end else n_bad++;
  end

  // ---------------- scoreboard ----------------
  typedef struct packed {
    logic       err;
    logic       flag;
    logic [7:0] regv;
    logic [15:0] gets;
    logic [15:0] sets;
  } exp_t;
  exp_t exp_q[$];
  logic exp_flag = 1'b0;
  int   exp_get = 0, exp_set = 0;

  function automatic logic [7:0] bench_next(input logic [7:0] v, input logic en, input logic man);
    logic [7:0] r;
    r = v;
    for (int b = 3; b <= 5; b++) r[b] = !en;   // block-protect bits
    if (man) r[7] = !en;                       // optional bit 7
    return r;
  endfunction

  task automatic request(input logic en, input logic man);
    exp_t e;
    logic [7:0] nv;
    if (en == exp_flag) begin
      e = '{err: 1'b0, flag: exp_flag, regv: flash_reg, gets: 16'(exp_get), sets: 16'(exp_set)};
    end else begin
      nv = bench_next(flash_reg, en, man);
      exp_get += 2;
      exp_set += 1;
      if (flash_lock) begin
        e = '{err: 1'b1, flag: exp_flag, regv: flash_reg, gets: 16'(exp_get), sets: 16'(exp_set)};
      end else begin
        exp_flag = en;
        e = '{err: 1'b0, flag: en, regv: nv, gets: 16'(exp_get), sets: 16'(exp_set)};
      end
    end
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_enable = en; cfg_manage_rwd = man;
    @(negedge clk);
    req_valid = 1'b0;
    if (e.gets == 16'(exp_get) && e.flag == exp_flag && !e.err && en == e.flag
        && exp_q.size() <= 1) begin
      // no-op path when state already held: done the cycle after the strobe
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic request_match(input logic en, input logic man);
    // R2: matching request answers in the next cycle, with no chip select
    exp_q.push_back('{err: 1'b0, flag: exp_flag, regv: flash_reg,
                      gets: 16'(exp_get), sets: 16'(exp_set)});
    @(negedge clk);
    req_valid = 1'b1; req_enable = en; cfg_manage_rwd = man;
    @(negedge clk);
    req_valid = 1'b0;
    check({31'd0, done}, 32'd1, "R2 done one cycle after strobe");
    check({31'd0, spi_cs_n}, 32'd1, "R2 chip select stays high");
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (exp_q.size() == 0) begin
          check(32'd1, 32'd0, "R9 unexpected done");
        end else begin
          e = exp_q.pop_front();
          check({31'd0, err}, {31'd0, e.err}, "R9 err");
          check({31'd0, wr_enabled}, {31'd0, e.flag}, "R9 wr_enabled");
          check({24'd0, flash_reg}, {24'd0, e.regv}, "R4/R5/R6 register value");
          check(n_get, {16'd0, e.gets}, "R4 read frame count");
          check(n_set, {16'd0, e.sets}, "R7 write frame count");
          check(n_bad, 0, "R3 frame format");
          check(n_wp_bad, 0, "R8 wp_n around frames");
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    check({31'd0, wp_n}, 32'd0, "R1 wp_n reset");
    check({31'd0, spi_cs_n}, 32'd1, "R1 cs_n reset");
    check({31'd0, spi_sck}, 32'd0, "R1 sck reset");
    check({31'd0, wr_enabled}, 32'd0, "R1 wr_enabled reset");
    check({31'd0, done}, 32'd0, "R1 done reset");
    rst_n = 1'b1;
    armed = 1'b1;
    flash_reg = 8'hBE;
    repeat (2) @(negedge clk);

    request_match(1'b0, 1'b0);   // R2 already protected
    request(1'b1, 1'b0);         // R4 R6: BE -> 86
    request_match(1'b1, 1'b1);   // R2 already enabled
    request(1'b0, 1'b1);         // R5: 86 -> BE
    request(1'b1, 1'b1);         // R5: BE -> 06
    request(1'b0, 1'b0);         // R4: 06 -> 3E
    flash_lock = 1'b1;
    request(1'b1, 1'b0);         // R9: mismatch, flag holds
    flash_lock = 1'b0;
    request(1'b1, 1'b0);         // R7: 3E -> 06
    flash_reg = 8'h41;
    request(1'b0, 1'b1);         // R6: 41 -> F9
    flash_reg = 8'hC7;
    request(1'b1, 1'b0);         // R6: C7 -> C7 keeps bit 7

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule